// File: doc/BRIEF.md
# Occupancy-Balanced Fetch Thread Selector

This block decides which hardware thread of a simultaneously multithreaded core fetches in a given cycle. It holds a program counter and an in-flight instruction count for each thread. Each cycle it grants fetch to one thread that is active and not stalled. The thread with the fewest instructions currently in the back end wins, so that back-end occupancy stays evenly shared. When several threads are level, a rotating pointer breaks the tie.

The grant, the granted thread's identifier and its fetch address are driven combinationally from the registered per-thread state and the current eligibility flags, in the same cycle. At the clock edge the granted thread's count grows by the fetch width and its program counter steps past the fetched group. Retire and squash returns from the back end lower the counts in the same edge. A redirect loads a new program counter for any thread. The thread count, fetch width, instruction size and counter widths are parameters. Up to eight threads are supported.

Top module: `icf_fetch_sel`

## Requirements
- R1: After reset every count is 0, thread i's program counter is RESET_PC + i*PC_STRIDE, and the tie pointer is thread 0. With all threads eligible, the first grant therefore goes to thread 0 at address RESET_PC.
- R2: A thread whose thr_active bit is 0, or whose thr_stall bit is 1, is never granted. When no thread is eligible, fetch_valid is 0.
- R3: Among eligible threads, one with the strictly lowest in-flight count is granted.
- R4: Among eligible threads that share the lowest count, the first one met scanning upward (with wrap) from the tie pointer wins. After each grant the pointer becomes the granted thread's number plus one, modulo the thread count. It is unchanged in a cycle with no grant.
- R5: When exactly one thread is eligible, that thread is granted in every such cycle.
- R6: fetch_pc equals the granted thread's program counter. After a grant without a redirect for that thread, that thread's counter has advanced by FETCH_W*INSTR_BYTES at the next cycle.
- R7: When redir_valid bit t is 1 at a clock edge, thread t's program counter becomes redir_pc bits [t*PC_W +: PC_W]. This takes priority over the sequential advance from a grant in the same cycle.
- R8: At each edge, a thread's count becomes its old count, plus FETCH_W if it was granted, minus its retire_cnt field, minus its squash_cnt field. All of these are applied together. The result is clamped to the range 0 to 2^CNT_W-1. Thread t's fields sit at bits [t*RET_W +: RET_W].
- R9: The grant follows the current cycle's thr_active and thr_stall without a cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NUM_THR | Thread holds a running context |
| thr_stall | input | NUM_THR | Thread must not fetch this cycle |
| retire_cnt | input | NUM_THR*RET_W | Per-thread instructions retired this cycle |
| squash_cnt | input | NUM_THR*RET_W | Per-thread instructions squashed this cycle |
| redir_valid | input | NUM_THR | Per-thread redirect strobe |
| redir_pc | input | NUM_THR*PC_W | Per-thread redirect target |
| fetch_valid | output | 1 | A thread is granted fetch |
| fetch_tid | output | TID_W | Granted thread number |
| fetch_pc | output | PC_W | Fetch address of the granted thread |

## Verification
The grant, thread number and fetch address are due in the same cycle as the eligibility flags that produce them. Count, program counter and pointer updates show up one clock after the stimulus that caused them, and they are seen through the next cycle's grant and address. The bench drives inputs just after the falling edge and samples one time unit later, before the rising edge. It advances its behavioural model of counts, addresses and pointer at that rising edge. So each comparison uses the state left by every earlier edge and the inputs of the present cycle.

// File: rtl/icf_pkg.sv
package icf_pkg;

    // Limit an occupancy value to the representable range of a counter.
    function automatic int clamp_count(input int value, input int ceiling);
        if (value < 0)
            return 0;
        if (value > ceiling)
            return ceiling;
        return value;
    endfunction

endpackage

// File: rtl/icf_thread_ctx.sv
module icf_thread_ctx #(
    parameter int              PC_W        = 32,
    parameter int              CNT_W       = 7,
    parameter int              RET_W       = 3,
    parameter int              FETCH_W     = 4,
    parameter int              INSTR_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic [RET_W-1:0] retire,
    input  logic [RET_W-1:0] squash,
    input  logic             redir_v,
    input  logic [PC_W-1:0]  redir_pc,
    output logic [PC_W-1:0]  pc_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int STEP    = FETCH_W * INSTR_BYTES;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [PC_W-1:0]  pc_q, pc_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    int               occ_sum;

    always_comb begin
        occ_sum = int'(cnt_q) + (grant ? FETCH_W : 0) - int'(retire) - int'(squash);
        cnt_d   = CNT_W'(icf_pkg::clamp_count(occ_sum, CNT_MAX));
    end

    always_comb begin
        if (redir_v)
            pc_d = redir_pc;
        else if (grant)
            pc_d = pc_q + PC_W'(STEP);
        else
            pc_d = pc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            cnt_q <= '0;
        end else begin
            pc_q  <= pc_d;
            cnt_q <= cnt_d;
        end
    end

    assign pc_o  = pc_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/icf_pick.sv
module icf_pick #(
    parameter int NUM_THR = 4,
    parameter int CNT_W   = 7,
    parameter int TID_W   = 2
) (
    input  logic [NUM_THR-1:0]       elig,
    input  logic [NUM_THR*CNT_W-1:0] cnt_flat,
    input  logic [TID_W-1:0]         rr_ptr,
    output logic                     gnt_valid,
    output logic [TID_W-1:0]         gnt_tid
);
    logic [CNT_W-1:0] best_cnt;
    int               idx;

    // Scan from the tie pointer; only a strictly smaller count displaces the
    // current holder, so the earliest thread in rotation wins a tie.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_tid   = '0;
        best_cnt  = '0;
        idx       = 0;
        for (int k = 0; k < NUM_THR; k++) begin
            idx = int'(rr_ptr) + k;
            if (idx >= NUM_THR)
                idx = idx - NUM_THR;
            if (elig[idx]) begin
                if (!gnt_valid || (cnt_flat[idx*CNT_W +: CNT_W] < best_cnt)) begin
                    gnt_valid = 1'b1;
                    gnt_tid   = TID_W'(idx);
                    best_cnt  = cnt_flat[idx*CNT_W +: CNT_W];
                end
            end
        end
    end

endmodule

// File: rtl/icf_fetch_sel.sv
module icf_fetch_sel #(
    parameter int              NUM_THR     = 4,
    parameter int              FETCH_W     = 4,
    parameter int              INSTR_BYTES = 4,
    parameter int              PC_W        = 32,
    parameter int              CNT_W       = 7,
    parameter int              RET_W       = 3,
    parameter logic [PC_W-1:0] RESET_PC    = 32'h0000_0100,
    parameter logic [PC_W-1:0] PC_STRIDE   = 32'h0000_1000,
    localparam int             TID_W       = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_THR-1:0]       thr_active,
    input  logic [NUM_THR-1:0]       thr_stall,
    input  logic [NUM_THR*RET_W-1:0] retire_cnt,
    input  logic [NUM_THR*RET_W-1:0] squash_cnt,
    input  logic [NUM_THR-1:0]       redir_valid,
    input  logic [NUM_THR*PC_W-1:0]  redir_pc,
    output logic                     fetch_valid,
    output logic [TID_W-1:0]         fetch_tid,
    output logic [PC_W-1:0]          fetch_pc
);
    logic [NUM_THR-1:0]       elig;
    logic [NUM_THR*PC_W-1:0]  pc_flat;
    logic [NUM_THR*CNT_W-1:0] cnt_flat;
    logic [TID_W-1:0]         rr_q;

    assign elig = thr_active & ~thr_stall;

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        icf_thread_ctx #(
            .PC_W        (PC_W),
            .CNT_W       (CNT_W),
            .RET_W       (RET_W),
            .FETCH_W     (FETCH_W),
            .INSTR_BYTES (INSTR_BYTES),
            .RESET_PC    (RESET_PC + PC_W'(i) * PC_STRIDE)
        ) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant    (fetch_valid && (fetch_tid == TID_W'(i))),
            .retire   (retire_cnt[i*RET_W +: RET_W]),
            .squash   (squash_cnt[i*RET_W +: RET_W]),
            .redir_v  (redir_valid[i]),
            .redir_pc (redir_pc[i*PC_W +: PC_W]),
            .pc_o     (pc_flat[i*PC_W +: PC_W]),
            .cnt_o    (cnt_flat[i*CNT_W +: CNT_W])
        );
    end

    icf_pick #(
        .NUM_THR (NUM_THR),
        .CNT_W   (CNT_W),
        .TID_W   (TID_W)
    ) u_pick (
        .elig      (elig),
        .cnt_flat  (cnt_flat),
        .rr_ptr    (rr_q),
        .gnt_valid (fetch_valid),
        .gnt_tid   (fetch_tid)
    );

    assign fetch_pc = pc_flat[int'(fetch_tid)*PC_W +: PC_W];

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fetch_valid)
            rr_q <= (fetch_tid == TID_W'(NUM_THR - 1)) ? '0 : fetch_tid + 1'b1;
    end

endmodule

// File: rtl/icf_fetch_sel_chk.sv
module icf_fetch_sel_chk #(
    parameter int NUM_THR     = 4,
    parameter int FETCH_W     = 4,
    parameter int INSTR_BYTES = 4,
    parameter int PC_W        = 32,
    parameter int CNT_W       = 7,
    parameter int TID_W       = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_THR-1:0]       thr_active,
    input logic [NUM_THR-1:0]       thr_stall,
    input logic [NUM_THR-1:0]       redir_valid,
    input logic [NUM_THR*PC_W-1:0]  redir_pc,
    input logic                     fetch_valid,
    input logic [TID_W-1:0]         fetch_tid,
    input logic [PC_W-1:0]          fetch_pc,
    input logic [NUM_THR*CNT_W-1:0] cnt_flat
);
    localparam int STEP = FETCH_W * INSTR_BYTES;

    logic [NUM_THR-1:0] ok_thr;
    logic [PC_W-1:0]    redir_sel;
    logic               win_is_min;

    assign ok_thr    = thr_active & ~thr_stall;
    assign redir_sel = redir_pc[int'(fetch_tid)*PC_W +: PC_W];

    always_comb begin
        win_is_min = 1'b1;
        for (int i = 0; i < NUM_THR; i++)
            if (ok_thr[i] && (cnt_flat[i*CNT_W +: CNT_W] < cnt_flat[int'(fetch_tid)*CNT_W +: CNT_W]))
                win_is_min = 1'b0;
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (thr_active[fetch_tid] && !thr_stall[fetch_tid])); // R2

    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_thr == '0) |-> !fetch_valid); // R2

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> win_is_min); // R3

    AST_SOLO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ok_thr) == 1) |-> (fetch_valid && ok_thr[fetch_tid])); // R5

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !redir_valid[fetch_tid]) ##1 (fetch_valid && fetch_tid == $past(fetch_tid))
        |-> fetch_pc == $past(fetch_pc) + PC_W'(STEP)); // R6

    AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && redir_valid[fetch_tid]) ##1 (fetch_valid && fetch_tid == $past(fetch_tid))
        |-> fetch_pc == $past(redir_sel)); // R7

endmodule

bind icf_fetch_sel icf_fetch_sel_chk #(
    .NUM_THR     (NUM_THR),
    .FETCH_W     (FETCH_W),
    .INSTR_BYTES (INSTR_BYTES),
    .PC_W        (PC_W),
    .CNT_W       (CNT_W),
    .TID_W       (TID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_active  (thr_active),
    .thr_stall   (thr_stall),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .fetch_valid (fetch_valid),
    .fetch_tid   (fetch_tid),
    .fetch_pc    (fetch_pc),
    .cnt_flat    (cnt_flat)
);

// File: tb/icf_fetch_sel_test.sv
module icf_fetch_sel_test;
    localparam int          NT       = 4;
    localparam int          FW       = 4;
    localparam int          IB       = 4;
    localparam int          PW       = 32;
    localparam int          CW       = 7;
    localparam int          RW       = 3;
    localparam int          TW       = 2;
    localparam logic [31:0] BASE_PC  = 32'h0000_0100;
    localparam logic [31:0] STRIDE   = 32'h0000_1000;
    localparam int          CLK_PER  = 10;
    localparam int          CMAX     = (1 << CW) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NT-1:0]    thr_active = '0;
    logic [NT-1:0]    thr_stall = '0;
    logic [NT*RW-1:0] retire_cnt = '0;
    logic [NT*RW-1:0] squash_cnt = '0;
    logic [NT-1:0]    redir_valid = '0;
    logic [NT*PW-1:0] redir_pc = '0;
    logic             fetch_valid;
    logic [TW-1:0]    fetch_tid;
    logic [PW-1:0]    fetch_pc;

    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;
    int          m_cnt[NT];
    logic [31:0] m_pc[NT];
    int          m_rr;
    bit          m_redir_prev[NT];

    always #(CLK_PER/2) clk = ~clk;

    icf_fetch_sel #(
        .NUM_THR(NT), .FETCH_W(FW), .INSTR_BYTES(IB), .PC_W(PW),
        .CNT_W(CW), .RET_W(RW), .RESET_PC(BASE_PC), .PC_STRIDE(STRIDE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_stall(thr_stall),
        .retire_cnt(retire_cnt), .squash_cnt(squash_cnt), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
        .fetch_pc(fetch_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_cnt[t] = 0;
            m_pc[t] = BASE_PC + 32'(t) * STRIDE;
            m_redir_prev[t] = 0;
        end
        m_rr = 0;
    endtask

    task automatic drive(input logic [NT-1:0] act, input logic [NT-1:0] stl);
        thr_active = act;
        thr_stall = stl;
        retire_cnt = '0;
        squash_cnt = '0;
        redir_valid = '0;
    endtask

    task automatic set_ret(input int t, input int r, input int q);
        retire_cnt[t*RW +: RW] = RW'(r);
        squash_cnt[t*RW +: RW] = RW'(q);
    endtask

    task automatic set_redir(input int t, input logic [31:0] pc);
        redir_valid[t] = 1'b1;
        redir_pc[t*PW +: PW] = pc;
    endtask

    // One cycle: compare outputs against the model, then advance the model at the edge.
    task automatic cycle(input string tag);
        bit    ev;
        int    et, n_el, n_min, c;
        string vt;
        #1;
        ev = 0; et = 0; n_el = 0;
        for (int k = 0; k < NT; k++) begin
            int idx = (m_rr + k) % NT;
            if (thr_active[idx] && !thr_stall[idx]) begin
                n_el++;
                if (!ev || m_cnt[idx] < m_cnt[et]) begin
                    ev = 1; et = idx;
                end
            end
        end
        n_min = 0;
        for (int t = 0; t < NT; t++)
            if (thr_active[t] && !thr_stall[t] && ev && m_cnt[t] == m_cnt[et]) n_min++;
        if (tag != "") vt = tag;
        else if (n_el == 0) vt = "R2";
        else if (n_el == 1) vt = "R5";
        else if (n_min > 1) vt = "R4";
        else vt = "R3";
        chk(fetch_valid == ev, (n_el == 0) ? "R2" : vt, "fetch_valid", fetch_valid, ev);
        if (ev) begin
            chk(fetch_tid == TW'(et), vt, "fetch_tid", fetch_tid, et);
            chk(fetch_pc == m_pc[et], m_redir_prev[et] ? "R7" : "R6", "fetch_pc", fetch_pc, m_pc[et]);
        end
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            c = m_cnt[t] + ((ev && et == t) ? FW : 0)
                - int'(retire_cnt[t*RW +: RW]) - int'(squash_cnt[t*RW +: RW]);
            m_cnt[t] = (c < 0) ? 0 : ((c > CMAX) ? CMAX : c);
            m_redir_prev[t] = redir_valid[t];
            if (redir_valid[t]) m_pc[t] = redir_pc[t*PW +: PW];
            else if (ev && et == t) m_pc[t] = m_pc[t] + 32'(FW * IB);
        end
        if (ev) m_rr = (et + 1) % NT;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state visible through the first grant
        drive('1, '0);
        cycle("R1");

        // R4: level counts rotate from the pointer
        for (int i = 0; i < 8; i++) begin drive('1, '0); cycle("R4"); end

        // R3: stalled threads fall behind, then win on return
        for (int i = 0; i < 4; i++) begin drive('1, 4'b0011); cycle(""); end
        for (int i = 0; i < 6; i++) begin drive('1, '0); cycle("R3"); end

        // R8: combined retire and squash, clamped at zero
        drive('1, 4'b1111);
        set_ret(2, 7, 7); set_ret(1, 3, 2); set_ret(0, 1, 0);
        cycle("R8");
        for (int i = 0; i < 6; i++) begin drive('1, '0); cycle("R8"); end

        // R5: a lone thread fetches every cycle and its count saturates
        for (int i = 0; i < 36; i++) begin drive(4'b1000, '0); cycle("R5"); end
        drive(4'b1001, '0); set_ret(3, 7, 0);
        cycle("R8");
        for (int i = 0; i < 4; i++) begin drive(4'b1001, '0); cycle("R8"); end

        // R2: nothing eligible
        drive('1, '1); cycle("R2");
        drive('0, '0); cycle("R2");
        drive(4'b0101, 4'b0101); cycle("R2");

        // R7: redirect on the granted thread and on an idle one
        drive('1, '0); set_redir(0, 32'h0000_8000); set_redir(1, 32'h0000_9000); set_redir(2, 32'h0000_A000); set_redir(3, 32'h0000_B000);
        cycle("R7");
        for (int i = 0; i < 4; i++) begin drive('1, '0); cycle("R7"); end

        // R9: eligibility changes take effect in the same cycle
        for (int i = 0; i < 8; i++) begin
            drive('1, 4'(1 << (i % NT)));
            cycle("R9");
        end

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            drive(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15) & $urandom_range(0, 15)));
            for (int t = 0; t < NT; t++) begin
                set_ret(t, $urandom_range(0, 3), ($urandom_range(0, 7) == 0) ? $urandom_range(0, 7) : 0);
                if ($urandom_range(0, 9) == 0) set_redir(t, $urandom & 32'hFFFF_FFFC);
            end
            cycle("");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule